// File: doc/BRIEF.md
# Processor Hang Monitor Controller

This block keeps watch over a host processor that can stop responding after a functional upset. Host software writes alive messages over a small register bus. Each message restarts a programmable check timer. If the timer runs out, the controller latches a hang flag and then tries to recover the host in stages of rising severity.

The first stage is a configurable interrupt pulse. The second is a timed reset pulse. The last stage is a power-cycle enable, held for a programmable number of cycles and then released. An alive message that arrives during any stage ends the recovery. The hang flag stays set until software clears it, so recovery code can tell after the fact that a hang took place.

Monitoring stays off after reset until software sets the enable bit. All timer lengths, the choice of interrupt, and the active level and pulse width of each interrupt are register fields. Registers are word-addressed:

| Address | Register | Fields |
|---|---|---|
| 0 | CTRL | bit 0 is enable; bits [10:8] select the interrupt |
| 1 | TIMEOUT | check timer length |
| 2 | RETRY | retry window length |
| 3 | HOLD | power-cycle hold length |
| 4 | STATUS | bit 0 is the hang flag |
| 5 | KICK | alive message |
| 8 + n | IRQ n config | bit 0 is the active level (1 means active-high); bits [15:8] are the pulse width |

Top module: `hang_monitor`

## Requirements
- R1: After reset, every `irq_o` bit is low, because each interrupt level field resets to 1 (active-high). `host_rst_o`, `pwr_cut_o` and `hang_o` are low, and CTRL reads 0, so monitoring is disabled.
- R2: While the enable bit (CTRL bit 0) is 0, the timer never expires and no recovery output is driven, however much time passes.
- R3: Any write to address 5 is an alive message and restarts the check timer. With monitoring enabled and no further message, `hang_o` (STATUS bit 0) rises exactly TIMEOUT cycles after the message is accepted. Messages spaced closer than TIMEOUT keep it low.
- R4: At expiry, the interrupt selected by CTRL bits [10:8] becomes active for WIDTH cycles, taken from bits [15:8] of its config word at address 8+n. Its active level comes from bit 0 of that word (1 drives high, 0 drives low). All other interrupts stay at their inactive level. A width of 0 gives no pulse.
- R5: If no alive message arrives within RETRY cycles after expiry, `host_rst_o` goes high for RST_CYCLES cycles.
- R6: If no alive message arrives within a further RETRY cycles after the reset pulse, `pwr_cut_o` goes high for HOLD cycles. It then drops and monitoring resumes with the timer restarted.
- R7: An alive message during any recovery stage returns the controller to monitoring at once. It releases `host_rst_o` and `pwr_cut_o` and leaves `hang_o` set.
- R8: The hang flag clears only when a 1 is written to STATUS bit 0. Writing 0 leaves it set, and a new expiry in the same cycle wins over a clear.
- R9: `bus_ready` is always high. A read returns the addressed register in the same cycle, and configuration registers read back what was written.
- R10: `host_rst_o` and `pwr_cut_o` are never high together, and power-cycle only ever follows the post-reset retry window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_ready | output | 1 | Access accepted (always high) |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| irq_o | output | 8 | Recovery interrupt lines |
| host_rst_o | output | 1 | Host reset, active high |
| pwr_cut_o | output | 1 | Power-cycle driver enable, active high |
| hang_o | output | 1 | Latched hang flag |

## Verification
The assertions check the following on every cycle:
- The disabled state stays idle.
- An alive message always ends recovery.
- The flag is sticky and is set on expiry.
- Power-cycle entry only follows the post-reset wait.
- A zero-width interrupt stays quiet.

Only the bench's scenarios can show the exact timing of the escalation. That covers expiry after TIMEOUT cycles, the interrupt width and level, the reset and power windows measured from the alive message, and register readback. These are checked cycle by cycle against expected windows under random timer lengths and interrupt settings, plus directed cases for recovery interrupted at each stage.

// File: rtl/hm_pkg.sv
// Package: shared state type and register addresses of the hang monitor.
// Assumes the number of interrupts is at least 8, so that the control
// addresses fit below the interrupt config region.
package hm_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_OFF,       // monitoring disabled
        ST_MON,       // check timer running
        ST_IRQ_WAIT,  // interrupt sent, waiting for alive message
        ST_RST,       // host reset asserted
        ST_RST_WAIT,  // reset done, waiting for alive message
        ST_PWR        // power-cycle enable asserted
    } hm_state_e;

    localparam int A_CTRL  = 0;
    localparam int A_TMO   = 1;
    localparam int A_RETRY = 2;
    localparam int A_HOLD  = 3;
    localparam int A_STAT  = 4;
    localparam int A_KICK  = 5;
    localparam int SEL_LSB = 8;  // CTRL interrupt select field
    localparam int WID_LSB = 8;  // IRQ config width field
endpackage

// File: rtl/hm_regs.sv
// Register file of the hang monitor. Decodes single-cycle bus accesses
// (ready is always high, reads are combinational), holds configuration,
// produces the alive-message pulse and keeps the sticky hang flag.
// Assumes CNT_W and WID_W fit into a data word.
module hm_regs #(
    parameter int NIRQ        = 8,
    parameter int CNT_W       = 24,
    parameter int WID_W       = 8,
    parameter int DEF_TIMEOUT = 1000,
    parameter int DEF_RETRY   = 100,
    parameter int DEF_HOLD    = 50,
    parameter int DEF_WIDTH   = 4,
    localparam int IDX_W      = $clog2(NIRQ),
    localparam int ADDR_W     = IDX_W + 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_valid,
    output logic                         bus_ready,
    input  logic                         bus_write,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [hm_pkg::DATA_W-1:0]    bus_wdata,
    output logic [hm_pkg::DATA_W-1:0]    bus_rdata,
    input  logic                         set_hang_i,
    output logic                         enable_o,
    output logic [IDX_W-1:0]             sel_o,
    output logic [CNT_W-1:0]             timeout_o,
    output logic [CNT_W-1:0]             retry_o,
    output logic [CNT_W-1:0]             hold_o,
    output logic                         hang_o,
    output logic                         kick_o,
    output logic [NIRQ-1:0]              lvl_o,
    output logic [NIRQ-1:0][WID_W-1:0]   wid_o
);
    import hm_pkg::*;

    logic wr, irq_sel, clr_hang;
    logic [IDX_W-1:0] idx;

    assign bus_ready = 1'b1;
    assign wr        = bus_valid && bus_write;
    assign irq_sel   = bus_addr[IDX_W];
    assign idx       = bus_addr[IDX_W-1:0];
    assign kick_o    = wr && !irq_sel && (bus_addr == ADDR_W'(A_KICK));
    assign clr_hang  = wr && !irq_sel && (bus_addr == ADDR_W'(A_STAT)) && bus_wdata[0];

    // Control and timer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o  <= 1'b0;
            sel_o     <= '0;
            timeout_o <= CNT_W'(DEF_TIMEOUT);
            retry_o   <= CNT_W'(DEF_RETRY);
            hold_o    <= CNT_W'(DEF_HOLD);
        end else if (wr && !irq_sel) begin
            case (bus_addr)
                ADDR_W'(A_CTRL): begin
                    enable_o <= bus_wdata[0];
                    sel_o    <= bus_wdata[SEL_LSB +: IDX_W];
                end
                ADDR_W'(A_TMO):   timeout_o <= bus_wdata[CNT_W-1:0];
                ADDR_W'(A_RETRY): retry_o   <= bus_wdata[CNT_W-1:0];
                ADDR_W'(A_HOLD):  hold_o    <= bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Per-interrupt level and width configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_o <= '1;
            for (int i = 0; i < NIRQ; i++) wid_o[i] <= WID_W'(DEF_WIDTH);
        end else if (wr && irq_sel) begin
            lvl_o[idx] <= bus_wdata[0];
            wid_o[idx] <= bus_wdata[WID_LSB +: WID_W];
        end
    end

    // Sticky hang flag: set on expiry (wins), cleared by write-one
    always_ff @(posedge clk) begin
        if (!rst_n)          hang_o <= 1'b0;
        else if (set_hang_i) hang_o <= 1'b1;
        else if (clr_hang)   hang_o <= 1'b0;
    end

    // Combinational read mux
    always_comb begin
        bus_rdata = '0;
        if (irq_sel) begin
            bus_rdata[0]                = lvl_o[idx];
            bus_rdata[WID_LSB +: WID_W] = wid_o[idx];
        end else begin
            case (bus_addr)
                ADDR_W'(A_CTRL): begin
                    bus_rdata[0]                = enable_o;
                    bus_rdata[SEL_LSB +: IDX_W] = sel_o;
                end
                ADDR_W'(A_TMO):   bus_rdata[CNT_W-1:0] = timeout_o;
                ADDR_W'(A_RETRY): bus_rdata[CNT_W-1:0] = retry_o;
                ADDR_W'(A_HOLD):  bus_rdata[CNT_W-1:0] = hold_o;
                ADDR_W'(A_STAT):  bus_rdata[0]         = hang_o;
                default: ;
            endcase
        end
    end

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hang_o && !clr_hang) |=> hang_o);
    assert_flag_on_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_hang_i |=> hang_o);
endmodule

// File: rtl/hm_fsm.sv
// Escalation state machine of the hang monitor. One shared counter times
// the check window, the retry windows, the reset pulse and the power hold.
// Any alive message during monitoring or recovery restarts monitoring.
// Assumes timer lengths are nonzero.
module hm_fsm #(
    parameter int CNT_W      = 24,
    parameter int RST_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] timeout_i,
    input  logic [CNT_W-1:0] retry_i,
    input  logic [CNT_W-1:0] hold_i,
    output logic             expire_o,
    output logic             host_rst_o,
    output logic             pwr_cut_o
);
    import hm_pkg::*;

    hm_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, limit;
    logic             at_limit;

    // Window length of the current stage
    always_comb begin
        case (st_q)
            ST_MON:                   limit = timeout_i;
            ST_IRQ_WAIT, ST_RST_WAIT: limit = retry_i;
            ST_RST:                   limit = CNT_W'(RST_CYCLES);
            ST_PWR:                   limit = hold_i;
            default:                  limit = '0;
        endcase
    end

    assign at_limit = (cnt_q == limit - 1'b1);

    // Next-state and counter logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q + 1'b1;
        if (!enable_i) begin
            st_d  = ST_OFF;
            cnt_d = '0;
        end else if (st_q == ST_OFF || kick_i) begin
            st_d  = ST_MON;
            cnt_d = '0;
        end else if (at_limit) begin
            cnt_d = '0;
            case (st_q)
                ST_MON:      st_d = ST_IRQ_WAIT;
                ST_IRQ_WAIT: st_d = ST_RST;
                ST_RST:      st_d = ST_RST_WAIT;
                ST_RST_WAIT: st_d = ST_PWR;
                default:     st_d = ST_MON;
            endcase
        end
    end

    // State and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_OFF;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign expire_o   = enable_i && !kick_i && (st_q == ST_MON) && at_limit;
    assign host_rst_o = (st_q == ST_RST);
    assign pwr_cut_o  = (st_q == ST_PWR);

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (st_q == ST_OFF && !host_rst_o && !pwr_cut_o));
    assert_kick_recovers_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && kick_i && st_q != ST_OFF) |=> (st_q == ST_MON && !host_rst_o && !pwr_cut_o));
    assert_pwr_after_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_cut_o) |-> $past(st_q) == ST_RST_WAIT);
endmodule

// File: rtl/hm_pulse.sv
// Interrupt pulse generator: on a trigger, drives its line to the
// configured active level for the configured number of cycles. A width
// of zero produces no pulse. Assumes the level is static during a pulse.
module hm_pulse #(
    parameter int WID_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic             level_i,
    input  logic [WID_W-1:0] width_i,
    output logic             irq_o
);
    logic [WID_W-1:0] cnt_q;

    // Remaining active cycles of the pulse
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (trig_i)         cnt_q <= width_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign irq_o = (cnt_q != '0) ? level_i : ~level_i;

    assert_zero_width_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i && width_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/hang_monitor.sv
// Top of the processor hang monitor: register file, escalation state
// machine and one pulse generator per interrupt line. The expiry event
// sets the hang flag and triggers the selected interrupt in one cycle.
module hang_monitor #(
    parameter int NIRQ        = 8,
    parameter int CNT_W       = 24,
    parameter int WID_W       = 8,
    parameter int RST_CYCLES  = 4,
    parameter int DEF_TIMEOUT = 1000,
    parameter int DEF_RETRY   = 100,
    parameter int DEF_HOLD    = 50,
    parameter int DEF_WIDTH   = 4,
    localparam int IDX_W      = $clog2(NIRQ),
    localparam int ADDR_W     = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NIRQ-1:0]   irq_o,
    output logic              host_rst_o,
    output logic              pwr_cut_o,
    output logic              hang_o
);
    logic                       enable, kick, expire;
    logic [IDX_W-1:0]           sel;
    logic [CNT_W-1:0]           timeout, retry, hold;
    logic [NIRQ-1:0]            lvl;
    logic [NIRQ-1:0][WID_W-1:0] wid;

    hm_regs #(
        .NIRQ(NIRQ), .CNT_W(CNT_W), .WID_W(WID_W),
        .DEF_TIMEOUT(DEF_TIMEOUT), .DEF_RETRY(DEF_RETRY),
        .DEF_HOLD(DEF_HOLD), .DEF_WIDTH(DEF_WIDTH)
    ) regs_i (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .set_hang_i(expire), .enable_o(enable), .sel_o(sel),
        .timeout_o(timeout), .retry_o(retry), .hold_o(hold),
        .hang_o(hang_o), .kick_o(kick), .lvl_o(lvl), .wid_o(wid)
    );

    hm_fsm #(.CNT_W(CNT_W), .RST_CYCLES(RST_CYCLES)) fsm_i (
        .clk(clk), .rst_n(rst_n), .enable_i(enable), .kick_i(kick),
        .timeout_i(timeout), .retry_i(retry), .hold_i(hold),
        .expire_o(expire), .host_rst_o(host_rst_o), .pwr_cut_o(pwr_cut_o)
    );

    for (genvar gi = 0; gi < NIRQ; gi++) begin : g_irq
        hm_pulse #(.WID_W(WID_W)) pulse_i (
            .clk(clk), .rst_n(rst_n),
            .trig_i(expire && (sel == IDX_W'(gi))),
            .level_i(lvl[gi]), .width_i(wid[gi]), .irq_o(irq_o[gi])
        );
    end
endmodule

// File: tb/hang_monitor_tb_top.sv
module hang_monitor_tb_top;
    localparam int RST_CYC = 4;
    localparam int NI      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [NI-1:0] irq_o;
    logic        host_rst_o, pwr_cut_o, hang_o;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    bit cfg_lvl [NI];

    always #5 clk = ~clk;

    hang_monitor #(.NIRQ(NI), .RST_CYCLES(RST_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .host_rst_o(host_rst_o),
        .pwr_cut_o(pwr_cut_o), .hang_o(hang_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 4'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output bit rdy);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 4'(a);
        #1 d = bus_rdata; rdy = bus_ready;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    function automatic bit in_win(int k, int lo, int len);
        return (k >= lo) && (k < lo + len);
    endfunction

    function automatic logic [NI-1:0] exp_irq(int k, int t, int sel, int w);
        logic [NI-1:0] v;
        for (int i = 0; i < NI; i++)
            v[i] = (i == sel && in_win(k, t, w)) ? cfg_lvl[i] : ~cfg_lvl[i];
        return v;
    endfunction

    // Full escalation trace starting from an alive message
    task automatic trace(input int t, input int r, input int h, input int sel, input int w);
        int bad_h = 0, bad_i = 0, bad_r = 0, bad_p = 0, bad_x = 0;
        wr(5, 0);
        for (int k = 0; k < t + 2*r + RST_CYC + h + 4; k++) begin
            if (hang_o !== (k >= t)) bad_h++;
            if (irq_o !== exp_irq(k, t, sel, w)) bad_i++;
            if (host_rst_o !== in_win(k, t + r, RST_CYC)) bad_r++;
            if (pwr_cut_o !== in_win(k, t + 2*r + RST_CYC, h)) bad_p++;
            if (host_rst_o && pwr_cut_o) bad_x++;
            @(negedge clk);
        end
        check(bad_h == 0, "R3 hang flag timing", bad_h, 0);
        check(bad_i == 0, "R4 interrupt pulse", bad_i, 0);
        check(bad_r == 0, "R5 reset pulse", bad_r, 0);
        check(bad_p == 0, "R6 power hold", bad_p, 0);
        check(bad_x == 0, "R10 exclusive outputs", bad_x, 0);
    endtask

    task automatic setup(input int t, input int r, input int h, input int sel);
        wr(0, 0);
        wr(4, 1);
        wr(1, t); wr(2, r); wr(3, h);
        wr(0, (sel << 8) | 1);
    endtask

    initial begin
        logic [31:0] d;
        bit rdy;
        for (int i = 0; i < NI; i++) cfg_lvl[i] = 1'b1;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(irq_o == '0 && !host_rst_o && !pwr_cut_o && !hang_o, "R1 reset outputs",
              {irq_o, host_rst_o, pwr_cut_o, hang_o}, 0);
        rd(0, d, rdy);
        check(d == 0, "R1 ctrl reset", d, 0);
        check(rdy, "R9 ready high", rdy, 1);
        rd(1, d, rdy);
        check(d == 1000, "R9 timeout default", d, 1000);

        // R2: disabled monitoring never expires
        wr(1, 20); wr(5, 0);
        repeat (80) @(negedge clk);
        check(!hang_o && !host_rst_o && !pwr_cut_o, "R2 disabled quiet", hang_o, 0);

        // R9: readback of configuration
        wr(2, 32'h00abcd); rd(2, d, rdy);
        check(d == 32'h00abcd, "R9 retry readback", d, 32'h00abcd);
        wr(8 + 3, 32'h0000_0700); rd(8 + 3, d, rdy);
        check(d == 32'h0000_0700, "R9 irq cfg readback", d, 32'h700);
        cfg_lvl[3] = 1'b0;

        // R3: random kicks spaced below the timeout keep the flag low
        begin
            int t = 40;
            setup(t, 10, 5, 0);
            for (int n = 0; n < 10; n++) begin
                wr(5, 0);
                repeat ($urandom_range(t - 4, 5)) @(negedge clk);
            end
            check(!hang_o, "R3 kicks prevent expiry", hang_o, 0);
        end

        // R3 R4 R5 R6: random escalation runs
        for (int it = 0; it < 8; it++) begin
            int t = $urandom_range(60, 20);
            int r = $urandom_range(30, 10);
            int h = $urandom_range(20, 5);
            int sel = $urandom_range(NI - 1, 0);
            int w = $urandom_range(12, 1);
            int lv = $urandom_range(1, 0);
            wr(0, 0);
            wr(8 + sel, (w << 8) | lv);
            cfg_lvl[sel] = lv[0];
            setup(t, r, h, sel);
            trace(t, r, h, sel, w);
        end

        // R4: zero width gives no pulse
        wr(0, 0);
        wr(8 + 6, 0); cfg_lvl[6] = 1'b0;
        setup(20, 15, 5, 6);
        trace(20, 15, 5, 6, 0);

        // R8: write zero keeps flag, write one clears it
        wr(4, 0);
        check(hang_o, "R8 write zero keeps flag", hang_o, 1);
        wr(4, 1);
        check(!hang_o, "R8 write one clears", hang_o, 0);

        // R7: kick during interrupt wait, reset, and power stages
        setup(20, 15, 30, 1);
        wr(5, 0);
        repeat (24) @(negedge clk);
        wr(5, 0);
        repeat (16) @(negedge clk);
        check(!host_rst_o && hang_o, "R7 kick in retry window", {host_rst_o, hang_o}, 1);
        while (!host_rst_o) @(negedge clk);
        wr(5, 0);
        check(!host_rst_o && !pwr_cut_o && hang_o, "R7 kick in reset", {host_rst_o, hang_o}, 1);
        while (!pwr_cut_o) @(negedge clk);
        repeat (3) @(negedge clk);
        wr(5, 0);
        check(!pwr_cut_o && hang_o, "R7 kick in power stage", {pwr_cut_o, hang_o}, 1);
        wr(4, 1);
        repeat (10) @(negedge clk);
        check(!hang_o && !host_rst_o, "R7 monitoring resumed", hang_o, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule